// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable model of a flow-through synchronous SRAM whose word is split into byte lanes. Each lane carries eight data bits and one parity bit. Every control input is sampled on the rising clock edge. An address is captured when one of two address strobes is accepted. The processor strobe has priority over the controller strobe. Three chip enables decide whether an accepted strobe starts an access or deselects the device. After a capture, a two-bit burst counter walks the four words of the aligned block that holds the captured address. It steps on an advance input, in linear or exclusive-or order. A static order input picks the order.

Reads are flow-through. After the edge that sets the current address, the read bus carries that word with no further register stage. The drive flag is an asynchronous function of the active-low output enable. It is held off for the first cycle of an access that starts from the deselected state. Writes have per-lane enables. They happen either on the edge that accepts the controller strobe, at the new address, or on any later edge of an active burst, at the current burst address.

Top module: `fts_burst_sram`

## Requirements
- R1: The device counts as selected only when `en0_n`=0, `en1`=1 and `en2_n`=0. An accepted strobe while not selected ends the burst (deselect).
- R2: While deselected (also after reset), `rdata` is all zeros and `rdata_drive` is 0.
- R3: `cpu_stb_n` is ignored while `en0_n`=1. With `ctl_stb_n` and `step_n` high, the current address and the burst state stay unchanged.
- R4: When both strobes are low and `en0_n`=0, only the processor strobe acts. That edge never writes, whatever `wr_n` is.
- R5: An accepted strobe while selected loads `addr` as the current address, and its two low bits become the burst start offset.
- R6: With a burst active and no strobe accepted, `step_n`=0 advances the burst step by one at the edge. `step_n`=1 keeps it.
- R7: With `order_sel`=0 (linear), address bits [1:0] at step k are (start+k) mod 4. The upper address bits never change during a burst.
- R8: With `order_sel`=1 (interleaved), address bits [1:0] at step k are start XOR k.
- R9: After each edge, `rdata` equals the stored word at the current address, including a word written at that same edge.
- R10: `rdata_drive` is 0 whenever `out_en_n`=1. It follows `out_en_n` without waiting for a clock edge.
- R11: In the cycle after a strobe that starts an access from the deselected state, `rdata_drive` is 0 even with `out_en_n`=0. In later cycles it is driven again.
- R12: Lane i is bits [9i+8:9i], and bit 9i+8 is its parity bit. A write stores lane i only when `lane_wr_n[i]`=0. Other lanes keep their contents.
- R13: When `wr_n`=0 and the controller strobe is accepted while selected, the edge writes `wdata` to `addr`. When `wr_n`=0 and no strobe is accepted while a burst is active, the edge writes to the current burst address before any advance, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en0_n | input | 1 | Chip enable, active low, also gates the processor strobe |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_n | input | 1 | Write request, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved; static |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*9 | Write data, lanes with parity |
| rdata | output | LANES*9 | Flow-through read data |
| rdata_drive | output | 1 | High when the read bus would be driven |

## Verification
Three events can fall on the same edge. A strobe can arrive while a write request is pending, and a strobe can arrive while the chip enables disagree. That one edge can then load, write, deselect or do nothing, and the four outcomes must be told apart. The bench first opens a burst at one address. It then drives all 32 combinations of the two strobes and the three enables with `wr_n` low, a fresh address and fresh data. It judges the result by whether the read bus shows the new data, the old word at the new address, zeros, or the new data at the old address. A later full read-back sweep confirms that no write landed where it should not.

// File: rtl/fts_burst_sram_pkg.sv
package fts_burst_sram_pkg;

    localparam int LANE_DATA_W = 8;
    localparam int LANE_W      = LANE_DATA_W + 1;
    localparam int BURST_W     = 2;

    typedef enum logic [2:0] {
        CMD_HOLD,
        CMD_DESEL,
        CMD_LOAD_PROC,
        CMD_LOAD_CTRL,
        CMD_ADVANCE
    } strobe_cmd_e;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic               active;
        logic               first_rd;
        logic [BURST_W-1:0] start;
        logic [BURST_W-1:0] step;
    } burst_state_t;

    function automatic logic chip_selected(input logic e0_n, input logic e1, input logic e2_n);
        return !e0_n && e1 && !e2_n;
    endfunction

    function automatic logic cmd_loads(input strobe_cmd_e c);
        return (c == CMD_LOAD_PROC) || (c == CMD_LOAD_CTRL);
    endfunction

    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input burst_order_e       ord
    );
        if (ord == ORDER_XOR) begin
            return start ^ step;
        end
        return start + step;
    endfunction

endpackage

// File: rtl/fts_strobe_decode.sv
module fts_strobe_decode
    import fts_burst_sram_pkg::*;
(
    input  logic        en0_n,
    input  logic        en1,
    input  logic        en2_n,
    input  logic        cpu_stb_n,
    input  logic        ctl_stb_n,
    input  logic        step_n,
    input  logic        wr_n,
    input  logic        burst_active,
    output strobe_cmd_e cmd,
    output logic        wr_now,
    output logic        wr_at_load
);

    logic selected;
    logic cpu_take;
    logic ctl_take;

    assign selected = chip_selected(en0_n, en1, en2_n);
    assign cpu_take = !cpu_stb_n && !en0_n;
    assign ctl_take = !ctl_stb_n && !cpu_take;

    always_comb begin
        if (cpu_take) begin
            cmd = selected ? CMD_LOAD_PROC : CMD_DESEL;
        end else if (ctl_take) begin
            cmd = selected ? CMD_LOAD_CTRL : CMD_DESEL;
        end else if (burst_active && !step_n) begin
            cmd = CMD_ADVANCE;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    always_comb begin
        wr_at_load = (cmd == CMD_LOAD_CTRL);
        unique case (cmd)
            CMD_LOAD_CTRL:         wr_now = !wr_n;
            CMD_HOLD, CMD_ADVANCE: wr_now = !wr_n && burst_active;
            default:               wr_now = 1'b0;
        endcase
    end

endmodule

// File: rtl/fts_burst_counter.sv
module fts_burst_counter
    import fts_burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_cmd_e       cmd,
    input  burst_order_e      order,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              burst_active,
    output logic              first_rd
);

    localparam int HI_W = ADDR_W - BURST_W;

    burst_state_t    st_q, st_d;
    logic [HI_W-1:0] hi_q, hi_d;

    always_comb begin
        st_d          = st_q;
        hi_d          = hi_q;
        st_d.first_rd = 1'b0;
        if (cmd_loads(cmd)) begin
            hi_d          = load_addr[ADDR_W-1:BURST_W];
            st_d.start    = load_addr[BURST_W-1:0];
            st_d.step     = '0;
            st_d.active   = 1'b1;
            st_d.first_rd = !st_q.active;
        end else begin
            unique case (cmd)
                CMD_DESEL:   st_d.active = 1'b0;
                CMD_ADVANCE: st_d.step   = st_q.step + BURST_W'(1);
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            hi_q <= '0;
        end else begin
            st_q <= st_d;
            hi_q <= hi_d;
        end
    end

    assign cur_addr     = {hi_q, burst_offset(st_q.start, st_q.step, order)};
    assign burst_active = st_q.active;
    assign first_rd     = st_q.first_rd;

endmodule

// File: rtl/fts_lane_store.sv
module fts_lane_store
    import fts_burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && !lane_wr_n[g]) begin
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
    import fts_burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en0_n,
    input  logic                    en1,
    input  logic                    en2_n,
    input  logic                    cpu_stb_n,
    input  logic                    ctl_stb_n,
    input  logic                    step_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    order_sel,
    input  logic                    out_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drive
);

    localparam int DATA_W = LANES * LANE_W;

    strobe_cmd_e       cmd;
    logic              wr_now;
    logic              wr_at_load;
    logic              burst_active;
    logic              first_rd;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] rd_word;
    burst_order_e      order;

    assign order = burst_order_e'(order_sel);

    fts_strobe_decode u_dec (
        .en0_n        (en0_n),
        .en1          (en1),
        .en2_n        (en2_n),
        .cpu_stb_n    (cpu_stb_n),
        .ctl_stb_n    (ctl_stb_n),
        .step_n       (step_n),
        .wr_n         (wr_n),
        .burst_active (burst_active),
        .cmd          (cmd),
        .wr_now       (wr_now),
        .wr_at_load   (wr_at_load)
    );

    fts_burst_counter #(.ADDR_W(ADDR_W)) u_ctr (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .order        (order),
        .load_addr    (addr),
        .cur_addr     (cur_addr),
        .burst_active (burst_active),
        .first_rd     (first_rd)
    );

    assign wr_addr = wr_at_load ? addr : cur_addr;

    fts_lane_store #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
        .clk       (clk),
        .wr_en     (wr_now),
        .wr_addr   (wr_addr),
        .lane_wr_n (lane_wr_n),
        .wr_data   (wdata),
        .rd_addr   (cur_addr),
        .rd_data   (rd_word)
    );

    assign rdata       = burst_active ? rd_word : '0;
    assign rdata_drive = !out_en_n && burst_active && !first_rd;

endmodule

// File: rtl/fts_burst_sram_chk.sv
module fts_burst_sram_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              en0_n,
    input logic              en1,
    input logic              en2_n,
    input logic              cpu_stb_n,
    input logic              ctl_stb_n,
    input logic              step_n,
    input logic              out_en_n,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_drive,
    input logic              burst_active
);

    logic sel_now;
    logic cpu_take;
    logic any_take;

    assign sel_now  = !en0_n && en1 && !en2_n;
    assign cpu_take = !cpu_stb_n && !en0_n;
    assign any_take = cpu_take || !ctl_stb_n;

    assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (any_take && !sel_now) |=> (rdata == '0 && !rdata_drive));

    assert_cpu_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (!cpu_stb_n && en0_n && ctl_stb_n && step_n)
            |=> ($stable(cur_addr) && burst_active == $past(burst_active)));

    assert_load_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (any_take && sel_now) |=> (cur_addr == $past(addr) && burst_active));

    assert_block_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (burst_active && !step_n && !any_take)
            |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])
                 && cur_addr[1:0] != $past(cur_addr[1:0])));

    assert_oe_off_R10: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rdata_drive);

    assert_first_mask_R11: assert property (@(posedge clk) disable iff (rst)
        (!burst_active && any_take && sel_now) |=> !rdata_drive);

endmodule

bind fts_burst_sram fts_burst_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .en0_n        (en0_n),
    .en1          (en1),
    .en2_n        (en2_n),
    .cpu_stb_n    (cpu_stb_n),
    .ctl_stb_n    (ctl_stb_n),
    .step_n       (step_n),
    .out_en_n     (out_en_n),
    .addr         (addr),
    .cur_addr     (cur_addr),
    .rdata        (rdata),
    .rdata_drive  (rdata_drive),
    .burst_active (burst_active)
);

// File: tb/sim_fts_burst_sram.sv
module sim_fts_burst_sram;

    localparam int AW    = 6;
    localparam int LN    = 4;
    localparam int DW    = LN * 9;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          en0_n, en1, en2_n;
    logic          cpu_stb_n, ctl_stb_n, step_n, wr_n;
    logic [LN-1:0] lane_wr_n;
    logic          order_sel, out_en_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    logic [DW-1:0] exp_mem [DEPTH];
    int            n_total = 0;
    int            n_fail  = 0;

    always #10 clk = ~clk;

    fts_burst_sram #(.ADDR_W(AW), .LANES(LN)) u0 (
        .clk(clk), .rst(rst), .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
        .wr_n(wr_n), .lane_wr_n(lane_wr_n), .order_sel(order_sel),
        .out_en_n(out_en_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        n_total++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic idle();
        en0_n = 0; en1 = 1; en2_n = 0;
        cpu_stb_n = 1; ctl_stb_n = 1; step_n = 1;
        wr_n = 1; lane_wr_n = '1; out_en_n = 0;
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int s);
        logic [31:0] h;
        h = 32'(a) * 32'd2654435761 ^ 32'(s) * 32'd40503 ^ 32'h5a5a_1234;
        return {4'(a + s), h};
    endfunction

    function automatic int burst_at(input int base, input int off, input int k, input int m);
        if (m == 1) return base + ((off ^ k) & 3);
        return base + ((off + k) & 3);
    endfunction

    task automatic deselect();
        idle();
        en1 = 0; ctl_stb_n = 0;
        tick();
        chk("R1 deselect data", rdata, '0);
        chk("R2 deselect drive", DW'(rdata_drive), '0);
        idle();
    endtask

    initial begin
        #(20 * 200000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        rst = 1; idle(); order_sel = 0; addr = '0; wdata = '0;
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R2 reset data", rdata, '0);
        chk("R2 reset drive", DW'(rdata_drive), '0);

        // Fill every word through the controller strobe (R13, R9)
        for (int a = 0; a < DEPTH; a++) begin
            idle();
            ctl_stb_n = 0; wr_n = 0; lane_wr_n = '0; addr = AW'(a); wdata = pat(a, 1);
            tick();
            exp_mem[a] = pat(a, 1);
            chk("R13 load write", rdata, exp_mem[a]);
        end
        idle();

        // Bursts in both orders from every start offset (R5..R8, R11)
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 3; b++) begin
                int base;
                base = (b == 0) ? 0 : ((b == 1) ? 20 : 60);
                for (int off = 0; off < 4; off++) begin
                    deselect();
                    order_sel = m[0];
                    if (off[0]) cpu_stb_n = 0; else ctl_stb_n = 0;
                    addr = AW'(base + off);
                    tick();
                    idle();
                    chk("R5 load data", rdata, exp_mem[base + off]);
                    chk("R11 first read masked", DW'(rdata_drive), '0);
                    for (int k = 1; k < 4; k++) begin
                        step_n = 0;
                        tick();
                        chk(m == 1 ? "R8 interleaved" : "R7 linear", rdata,
                            exp_mem[burst_at(base, off, k, m)]);
                        chk("R11 later drive", DW'(rdata_drive), DW'(1));
                    end
                    step_n = 1;
                    tick();
                    chk("R6 hold", rdata, exp_mem[burst_at(base, off, 3, m)]);
                    step_n = 0;
                    tick();
                    chk("R7 wrap", rdata, exp_mem[burst_at(base, off, 4, m)]);
                    idle();
                end
            end
        end

        // New strobe while active: no mask (R11)
        ctl_stb_n = 0; addr = 6'd33;
        tick();
        idle();
        chk("R11 no mask when active", DW'(rdata_drive), DW'(1));
        chk("R9 read", rdata, exp_mem[33]);

        // Output enable without a clock edge (R10)
        #2 out_en_n = 1;
        #1 chk("R10 off async", DW'(rdata_drive), '0);
        #2 out_en_n = 0;
        #1 chk("R10 on async", DW'(rdata_drive), DW'(1));
        tick();

        // All strobe and enable combinations with a write pending (R1, R3, R4, R13)
        for (int c = 0; c < 32; c++) begin
            int p, q;
            logic e0, e1v, e2, sp, sc, sel, ptake, ctake;
            logic [DW-1:0] d, expv;
            p = c; q = 32 + c;
            idle();
            ctl_stb_n = 0; addr = AW'(p);
            tick();
            e0 = c[0]; e1v = c[1]; e2 = c[2]; sp = c[3]; sc = c[4];
            d = pat(c, 7);
            en0_n = e0; en1 = e1v; en2_n = e2; cpu_stb_n = sp; ctl_stb_n = sc;
            step_n = 1; wr_n = 0; lane_wr_n = '0; addr = AW'(q); wdata = d;
            tick();
            sel = !e0 && e1v && !e2;
            ptake = !sp && !e0;
            ctake = !sc && !ptake;
            if ((ptake || ctake) && !sel) begin
                expv = '0;
                chk("R1 combo deselect", rdata, expv);
            end else if (ptake) begin
                expv = exp_mem[q];
                chk("R4 processor wins no write", rdata, expv);
            end else if (ctake) begin
                exp_mem[q] = d;
                chk("R13 combo ctl write", rdata, d);
            end else begin
                exp_mem[p] = d;
                chk("R3 combo ignored, burst write", rdata, d);
            end
        end
        idle();

        // Per-lane write masks (R12)
        ctl_stb_n = 0; addr = 6'd45;
        tick();
        idle();
        for (int mk = 0; mk < 16; mk++) begin
            logic [DW-1:0] d;
            d = pat(mk, 9);
            wr_n = 0; lane_wr_n = LN'(mk); wdata = d;
            tick();
            for (int l = 0; l < LN; l++)
                if (!mk[l]) exp_mem[45][l*9 +: 9] = d[l*9 +: 9];
            chk("R12 lane mask", rdata, exp_mem[45]);
        end
        idle();

        // Writes while advancing (R13, R7 or R8 with current order)
        ctl_stb_n = 0; addr = 6'd42;
        tick();
        idle();
        for (int k = 0; k < 4; k++) begin
            logic [DW-1:0] d;
            d = pat(k, 11);
            wr_n = 0; lane_wr_n = '0; step_n = 0; wdata = d;
            tick();
            exp_mem[burst_at(40, 2, k, int'(order_sel))] = d;
            chk("R13 burst write", rdata, exp_mem[burst_at(40, 2, k + 1, int'(order_sel))]);
        end
        idle();

        // Full read-back through the processor strobe (R9)
        for (int a = 0; a < DEPTH; a++) begin
            cpu_stb_n = 0; addr = AW'(a);
            tick();
            chk("R9 readback", rdata, exp_mem[a]);
        end
        idle();

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule